// File: doc/BRIEF.md
# UART Buffer Register Front End

This block puts four byte-wide registers in front of a small receive queue and a small transmit queue for a serial port. A host polls a status register to learn how many received bytes are waiting and how much transmit space is left. Each count is a 3-bit field that saturates at 7. The host then pops received bytes through a data register and pushes outgoing bytes through another. A control register can flush either queue, or clear the sticky flags, independently of one another.

The serial bit engine is not part of this block. It appears as a byte strobe on the receive side, which cannot be stalled, and as a valid/ready byte stream on the transmit side. A change output pulses whenever the status value moves, so the host can limit its polling to those moments. Register reads are registered: the data appears one cycle after the read strobe. Register selects are: 0 control, 1 status, 2 receive data, 3 transmit data.

Top module: `uart_buf_regs`

## Requirements
- R1: The status register reads `{bit7=0, bit6=overflow, bits5:3=transmit free space, bits2:0=receive bytes available}`, with both counts saturating at 7; after reset it reads 0x38.
- R2: A read strobe at select 2 returns the oldest received byte on rdata_o in the next cycle and removes it; bytes come out in arrival order.
- R3: A read of select 2 while the receive queue is empty returns 0x00 and leaves the status unchanged.
- R4: A byte strobed in while the receive queue is full, with no pop in the same cycle, is dropped and sets status bit 6, which stays set until cleared; with a same-cycle pop the byte is accepted and no overflow is flagged.
- R5: A write to select 3 queues a byte; tx_valid_o/tx_byte_o present the oldest queued byte, which holds until it leaves on tx_valid_o and tx_ready_i together; order is preserved.
- R6: A write to select 3 while the transmit queue (7 bytes) is full is dropped and never appears at tx_byte_o.
- R7: Writing select 0 with bit 0 set empties the receive queue, bit 1 empties the transmit queue, and bit 2 clears the overflow flag, each independently; a flush beats a same-cycle receive byte.
- R8: An overflow in the same cycle as a flag clear leaves the overflow flag set.
- R9: change_o is high exactly in the first cycle in which the status value differs from that of the previous cycle, and is low otherwise.
- R10: Reads of select 0 and select 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| change_o | output | 1 | Status change pulse |
| rx_byte_i | input | 8 | Byte from serial receiver |
| rx_valid_i | input | 1 | Receiver byte strobe |
| tx_byte_o | output | 8 | Byte to serial transmitter |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_ready_i | input | 1 | Transmitter takes the byte |

## Verification
The bench fills the receive queue past its limit. A design that let the count wrap past 7, or that forgot the sticky flag after draining, would show the wrong status. It also pops and pushes the full receive queue in one cycle, where a design testing fullness before the pop would raise a false overflow. It issues a flag clear in the same cycle as an overflow, and a flush in the same cycle as an incoming byte; a wrong priority shows up directly in the status byte. An empty read and a flag clear with no effect must produce neither a data change nor a change pulse.

// File: rtl/uart_buf_pkg.sv
package uart_buf_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_RXD  = 2'd2,
    REG_TXD  = 2'd3
  } reg_sel_e;

  localparam int CTRL_FLUSH_RX  = 0;
  localparam int CTRL_FLUSH_TX  = 1;
  localparam int CTRL_CLR_FLAGS = 2;
  localparam int FIELD_W        = 3;
  localparam int FIELD_MAX      = (1 << FIELD_W) - 1;

  function automatic logic [FIELD_W-1:0] sat_field(int unsigned v);
    return (v > FIELD_MAX) ? FIELD_W'(FIELD_MAX) : FIELD_W'(v);
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 7,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          drop_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic full, do_pop, do_push;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o && !flush_i;
  // a pop in the same cycle frees a slot for the push
  assign do_push = push_i && !flush_i && (!full || do_pop);
  assign drop_o  = push_i && !flush_i && !do_push;
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  // R6
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i && !flush_i) |=> (cnt_q == CW'(DEPTH)) && $stable(wr_q));
endmodule

// File: rtl/status_track.sv
module status_track
  import uart_buf_pkg::*;
#(
  parameter int RX_DEPTH = 7,
  parameter int TX_DEPTH = 7,
  localparam int RX_CW   = $clog2(RX_DEPTH + 1),
  localparam int TX_CW   = $clog2(TX_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RX_CW-1:0] rx_cnt_i,
  input  logic [TX_CW-1:0] tx_cnt_i,
  input  logic             ovf_i,
  output logic [7:0]       status_o,
  output logic             change_o
);
  localparam logic [7:0] RST_STAT = {2'b00, sat_field(TX_DEPTH), FIELD_W'(0)};

  logic [7:0] prev_q;

  assign status_o = {1'b0, ovf_i,
                     sat_field(TX_DEPTH - int'(tx_cnt_i)),
                     sat_field(int'(rx_cnt_i))};
  assign change_o = (status_o != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_STAT;
    else         prev_q <= status_o;
  end

  // R9
  change_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_o |=> (prev_q == $past(status_o)));
endmodule

// File: rtl/uart_buf_regs.sv
module uart_buf_regs
  import uart_buf_pkg::*;
#(
  parameter int RX_DEPTH = 7,
  parameter int TX_DEPTH = 7,
  parameter int DW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          change_o,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          rx_valid_i,
  output logic [DW-1:0] tx_byte_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i
);
  localparam int RX_CW = $clog2(RX_DEPTH + 1);
  localparam int TX_CW = $clog2(TX_DEPTH + 1);

  reg_sel_e sel;
  logic ctrl_wr, flush_rx, flush_tx, clr_flags;
  logic rx_pop, tx_push, tx_pop;
  logic [DW-1:0] rx_head, tx_head;
  logic [RX_CW-1:0] rx_cnt;
  logic [TX_CW-1:0] tx_cnt;
  logic rx_empty, tx_empty, rx_drop, tx_drop;
  logic ovf_q;
  logic [7:0] status;

  assign sel       = reg_sel_e'(addr_i);
  assign ctrl_wr   = wr_en_i && (sel == REG_CTRL);
  assign flush_rx  = ctrl_wr && wdata_i[CTRL_FLUSH_RX];
  assign flush_tx  = ctrl_wr && wdata_i[CTRL_FLUSH_TX];
  assign clr_flags = ctrl_wr && wdata_i[CTRL_CLR_FLAGS];
  assign rx_pop    = rd_en_i && (sel == REG_RXD);
  assign tx_push   = wr_en_i && (sel == REG_TXD);
  assign tx_valid_o = !tx_empty;
  assign tx_pop    = tx_valid_o && tx_ready_i;
  assign tx_byte_o = tx_valid_o ? tx_head : '0;

  byte_fifo #(.DEPTH(RX_DEPTH), .DW(DW)) rx_fifo_i (
    .clk_i, .rst_ni,
    .flush_i (flush_rx),
    .push_i  (rx_valid_i),
    .data_i  (rx_byte_i),
    .pop_i   (rx_pop),
    .data_o  (rx_head),
    .count_o (rx_cnt),
    .empty_o (rx_empty),
    .drop_o  (rx_drop)
  );

  byte_fifo #(.DEPTH(TX_DEPTH), .DW(DW)) tx_fifo_i (
    .clk_i, .rst_ni,
    .flush_i (flush_tx),
    .push_i  (tx_push),
    .data_i  (wdata_i),
    .pop_i   (tx_pop),
    .data_o  (tx_head),
    .count_o (tx_cnt),
    .empty_o (tx_empty),
    .drop_o  (tx_drop)
  );

  // a new overflow outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (rx_drop)   ovf_q <= 1'b1;
    else if (clr_flags) ovf_q <= 1'b0;
  end

  status_track #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) stat_i (
    .clk_i, .rst_ni,
    .rx_cnt_i (rx_cnt),
    .tx_cnt_i (tx_cnt),
    .ovf_i    (ovf_q),
    .status_o (status),
    .change_o (change_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_en_i) begin
      unique case (sel)
        REG_STAT: rdata_o <= DW'(status);
        REG_RXD:  rdata_o <= rx_empty ? '0 : rx_head;
        default:  rdata_o <= '0;
      endcase
    end
  end

  // R4
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_flags) |=> ovf_q);

  // R8
  ovf_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_drop |=> ovf_q);

  // R3
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop && rx_empty) |=> (rdata_o == '0));

  // R5
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !flush_tx) |=> tx_valid_o && $stable(tx_byte_o));

  // R6
  tx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_drop && !tx_pop) |=> !tx_empty && $stable(tx_cnt));
endmodule

// File: tb/uart_buf_regs_tb_top.sv
`timescale 1ns/1ps
module uart_buf_regs_tb_top;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_RXD = 2'd2, A_TXD = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0, rdata, rx_byte = '0, tx_byte;
  logic rx_valid = 1'b0, tx_ready = 1'b0, tx_valid, change;

  int checks = 0;
  int errors = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  uart_buf_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .change_o(change), .rx_byte_i(rx_byte),
    .rx_valid_i(rx_valid), .tx_byte_o(tx_byte), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // driver: issue a read, scoreboard the expected value
  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rxp(input logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // monitor: compare read data one cycle after the strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk(rdata, 8'hxx, "scoreboard underrun");
      else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({7'd0, change}, 8'h00, "R9 quiet after reset");
    chk({7'd0, tx_valid}, 8'h00, "R5 no tx after reset");
    rd(A_STAT, 8'h38, "R1 reset status");
    rd(A_RXD, 8'h00, "R3 empty rx read");
    chk({7'd0, change}, 8'h00, "R3 no change on empty read");
    rd(A_STAT, 8'h38, "R3 status unchanged");

    rxp(8'hA1);
    chk({7'd0, change}, 8'h01, "R9 pulse on rx byte");
    @(negedge clk);
    chk({7'd0, change}, 8'h00, "R9 pulse one cycle");
    rd(A_STAT, 8'h39, "R1 rx count 1");
    for (int i = 1; i < 7; i++) rxp(8'hA1 + 8'(i));
    rd(A_STAT, 8'h3F, "R1 rx count 7");
    rxp(8'hEE);
    chk({7'd0, change}, 8'h01, "R4 pulse on overflow");
    rd(A_STAT, 8'h7F, "R4 overflow flagged");
    for (int i = 0; i < 7; i++) rd(A_RXD, 8'hA1 + 8'(i), "R2 rx order");
    rd(A_STAT, 8'h78, "R4 overflow sticky");
    rd(A_RXD, 8'h00, "R3 read after drain");
    wr(A_CTRL, 8'h04);
    chk({7'd0, change}, 8'h01, "R9 pulse on flag clear");
    rd(A_STAT, 8'h38, "R7 flags cleared");

    for (int i = 0; i < 3; i++) wr(A_TXD, 8'h10 + 8'(i));
    rd(A_STAT, 8'h20, "R1 tx free 4");
    chk({7'd0, tx_valid}, 8'h01, "R5 tx valid");
    chk(tx_byte, 8'h10, "R5 tx head");
    for (int i = 3; i < 8; i++) wr(A_TXD, 8'h10 + 8'(i));
    rd(A_STAT, 8'h00, "R6 tx full");
    for (int i = 0; i < 7; i++) begin
      chk(tx_byte, 8'h10 + 8'(i), "R5 tx order");
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
    chk({7'd0, tx_valid}, 8'h00, "R6 dropped byte never sent");
    rd(A_STAT, 8'h38, "R5 tx drained");

    rxp(8'h51); rxp(8'h52); rxp(8'h53);
    wr(A_TXD, 8'h61); wr(A_TXD, 8'h62);
    rd(A_STAT, 8'h2B, "R1 mixed counts");
    wr(A_CTRL, 8'h01);
    rd(A_STAT, 8'h28, "R7 rx flush only");
    chk(tx_byte, 8'h61, "R7 tx kept on rx flush");
    rd(A_RXD, 8'h00, "R7 rx flushed");
    wr(A_CTRL, 8'h02);
    rd(A_STAT, 8'h38, "R7 tx flush");
    chk({7'd0, tx_valid}, 8'h00, "R7 tx empty after flush");
    wr(A_CTRL, 8'h04);
    chk({7'd0, change}, 8'h00, "R9 no pulse without status change");

    rd(A_CTRL, 8'h00, "R10 control reads zero");
    rd(A_TXD, 8'h00, "R10 tx data reads zero");

    for (int i = 0; i < 7; i++) rxp(8'h71 + 8'(i));
    addr = A_RXD; rd_en = 1'b1; rx_byte = 8'h78; rx_valid = 1'b1;
    exp_q.push_back(8'h71); tag_q.push_back("R2 pop while full");
    @(negedge clk);
    rd_en = 1'b0; rx_valid = 1'b0;
    rd(A_STAT, 8'h3F, "R4 accept with same-cycle pop");

    addr = A_CTRL; wdata = 8'h04; wr_en = 1'b1; rx_byte = 8'h79; rx_valid = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rx_valid = 1'b0;
    rd(A_STAT, 8'h7F, "R8 overflow beats clear");

    addr = A_CTRL; wdata = 8'h01; wr_en = 1'b1; rx_byte = 8'h80; rx_valid = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rx_valid = 1'b0;
    rd(A_STAT, 8'h78, "R7 flush beats rx byte");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule